// File: doc/BRIEF.md
# Instruction Store with Sequential Loader

This block is a clocked instruction store of 512 words of 32 bits for a small pipelined processor. In normal operation the fetch stage presents a 9-bit word address, and the stored instruction appears on the output one clock later.

Programs are placed in the store through a loading port. The loader holds a load-enable input high and supplies one instruction per clock on the load-data input. An internal write pointer puts each word at the address after the previous one. The pointer starts from address zero on reset and again on every new load burst, and it stops once the top address has been written. For as long as loading lasts, the block drives a stall output so the pipeline holds still. A fetch issued during loading returns undefined data, and the consumer must discard it.

Top module: `imem_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `stall` is 0.
- R2: A read has exactly one cycle of latency: the word at `rd_addr` sampled on a rising clock edge appears on `rd_data` after that edge and holds until the next edge.
- R3: A load burst begins on the first clock edge where `load_en` is 1 after having been 0. That edge writes `load_data` to address 0, and each further edge with `load_en` high writes the next word to the next higher address.
- R4: `stall` equals the value `load_en` had at the previous clock edge. It rises after the first write of a burst and falls one cycle after `load_en` goes low.
- R5: A new burst restarts writing at address 0. It overwrites only as many words as it supplies and leaves the higher addresses unchanged.
- R6: After address 511 has been written within a burst, further words in the same burst are ignored: no address changes, including addresses 0 and 511.
- R7: While `load_en` is 0, `load_data` has no effect on the stored contents.
- R8: All 512 addresses hold independent words, and each one reads back exactly as it was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for reads, writes and stall |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer and stall |
| load_en | input | 1 | High while a program is being loaded |
| load_data | input | 32 | Instruction word written during loading |
| rd_addr | input | 9 | Fetch word address |
| rd_data | output | 32 | Fetched instruction, one cycle after the address |
| stall | output | 1 | Pipeline hold request during loading |

## Verification
Several behaviours are checked by properties on every cycle. These are the one-cycle relation between `stall` and `load_en`, the pointer restart at the start of each burst, the one-step pointer advance while a burst is under way, the frozen pointer once the top address is written, and the idle pointer while loading is off. The bench scenarios cover what only the stored contents can show. These are one-cycle read latency, that an idle data bus leaves the contents alone, that a short reload overwrites only its own range, that an overlong burst leaves every word intact, and a full read-back of all 512 words.

// File: rtl/imem_loader.sv
module imem_loader #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             stall
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    wr_addr;
  logic             done;
  logic             first;
  logic             wr_ok;

  // stall doubles as the delayed copy of load_en for burst-start detection
  assign first   = load_en & ~stall;
  assign wr_addr = first ? '0 : ptr;
  assign wr_ok   = load_en & (first | ~done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall <= 1'b0;
      ptr   <= '0;
      done  <= 1'b0;
    end else begin
      stall <= load_en;
      if (wr_ok) begin
        ptr  <= AW'(wr_addr + 1'b1);
        done <= (wr_addr == AW'(DEPTH - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= load_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/imem_loader_chk.sv
module imem_loader_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_en,
  input logic          stall,
  input logic [AW-1:0] ptr,
  input logic          done
);

  // R1
  stall_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !stall);

  // R4
  stall_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall == $past(load_en));

  // R3
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !stall) |=> (ptr == AW'(1)) && !done);

  // R3
  pointer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && stall && !done) |=> ptr == AW'($past(ptr) + 1'b1));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && stall && done) |=> $stable(ptr) && done);

  // R7
  idle_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ptr) && $stable(done));

endmodule

bind imem_loader imem_loader_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .stall(stall),
  .ptr(ptr), .done(done)
);

// File: tb/imem_loader_tb.sv
`timescale 1ns/1ps
module imem_loader_tb_top;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        stall;

  logic [31:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  imem_loader dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall)
  );

  function automatic logic [31:0] pat(input int seed, input int i);
    return 32'hA500_0000 ^ (32'(seed) << 20) ^ (32'(i) * 32'h0001_9E37);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    load_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stall in reset", {31'b0, stall}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stall after reset", {31'b0, stall}, 32'd0);
  endtask

  // Drives n words in one burst; the model applies start-at-zero and stop-at-top.
  task automatic load_burst(input int n, input int seed, input string req);
    int wp = 0;
    bit full = 0;
    for (int i = 0; i < n; i++) begin
      load_en = 1'b1;
      load_data = pat(seed, i);
      if (!full) begin
        model[wp] = pat(seed, i);
        if (wp == DEPTH - 1) full = 1; else wp++;
      end
      @(negedge clk);
      check({req, " R4 stall high"}, {31'b0, stall}, 32'd1);
    end
    load_en = 1'b0;
    load_data = 32'hDEAD_BEEF;
    @(negedge clk);
    check({req, " R4 stall low"}, {31'b0, stall}, 32'd0);
  endtask

  task automatic read_range(input int lo, input int hi, input string req);
    for (int a = lo; a <= hi; a++) begin
      rd_addr = 9'(a);
      @(negedge clk);
      check(req, rd_data, model[a]);
    end
  endtask

  task automatic t_latency();
    rd_addr = 9'd3;
    @(negedge clk);
    check("R2 first read", rd_data, model[3]);
    rd_addr = 9'd7;
    #1;
    check("R2 held before edge", rd_data, model[3]);
    @(negedge clk);
    check("R2 after edge", rd_data, model[7]);
  endtask

  task automatic t_idle_data();
    for (int i = 0; i < 8; i++) begin
      load_data = ~pat(9, i);
      @(negedge clk);
      check("R7 stall idle", {31'b0, stall}, 32'd0);
    end
    read_range(0, 19, "R7 contents unchanged");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    load_burst(20, 1, "R3");
    read_range(0, 19, "R3 sequential load");
    t_latency();
    t_idle_data();
    load_burst(5, 2, "R5");
    read_range(0, 19, "R5 reload from zero");
    load_burst(DEPTH + 10, 3, "R6");
    read_range(0, 3, "R6 low words not overwritten");
    read_range(DEPTH - 2, DEPTH - 1, "R6 top word kept");
    read_range(0, DEPTH - 1, "R8 full readback");
    finish_up();
  end
endmodule